// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line back into parallel bytes. It runs from the same once-per-sixteenth-bit enable that clocks the companion transmitter. The line idles high. A low level seen on an enable tick opens a frame. The block looks at the line again half a bit later to confirm the start bit, then samples every later bit at its centre. It collects five to eight data bits, least significant first, then an optional parity bit and the stop bit.

Each completed word is placed in a read-only holding register along with its parity and framing status. A data-ready flag tells the host that a byte is waiting. A one-cycle read strobe consumes the byte. If a further word arrives before the host reads, the overrun flag is raised. Word length and parity are run-time inputs shared with the transmitter and are captured when each frame begins.

Top module: `serial_rx_top`

## Requirements
- R1: While reset is held and right after it, `rx_byte` is 0 and `data_ready`, `parity_err`, `framing_err` and `overrun` are all 0.
- R2: If the line returns high before the eighth `tick16` after a low level was first seen while idle, the frame is dropped. No byte is stored and no flag changes.
- R3: Data bits arrive least significant first. `word_len` selects the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The assembled word appears on `rx_byte`.
- R4: When the word is shorter than 8 bits, the bits of `rx_byte` above the word read as 0.
- R5: When `parity_en` is 1, one parity bit follows the data bits. With `parity_odd` at 0 the data bits plus the parity bit must hold an even number of ones; with `parity_odd` at 1 they must hold an odd number. A mismatch sets `parity_err` with the byte. When `parity_en` is 0, no parity bit is expected and `parity_err` stays 0.
- R6: A stop bit sampled low sets `framing_err` with the byte.
- R7: Storing a byte sets `data_ready`. A one-cycle `rd_strobe` with no word completing in that cycle clears `data_ready`, `parity_err`, `framing_err` and `overrun` on the next cycle.
- R8: A word that completes while `data_ready` is 1 and no read occurs sets `overrun`. The unread byte and its error flags are kept, and the new word is discarded.
- R9: After the start check, every bit is sampled 16 `tick16` enables after the previous sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_byte | output | 8 | Received word, zero-extended |
| data_ready | output | 1 | Holding register contains an unread byte |
| parity_err | output | 1 | Parity mismatch on the held byte |
| framing_err | output | 1 | Stop bit was low on the held byte |
| overrun | output | 1 | A word was lost because the buffer was full |

## Verification
The bench covers every word length with no parity, even parity and odd parity. The data patterns carry stray upper bits, so a receiver with an off-by-one bit count or a missing mask would show wrong high bits or a shifted value. A corrupted parity bit and a low stop bit exercise the error flags, which a receiver with an inverted parity sense or a skipped stop check would fail to raise. A glitch shorter than half a bit checks that a receiver without the start re-check does not produce a phantom byte. Two back-to-back words with no read in between check that the second word neither overwrites the first nor leaves `overrun` clear.

// File: rtl/serial_rx_pkg.sv
// Shared types and helpers for the serial receiver.
// Assumes word lengths are coded as (bits - MIN_BITS) in a 2-bit field.
package serial_rx_pkg;
    typedef enum logic [2:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_PAR,
        RXS_STOP
    } rx_state_t;

    localparam int MIN_BITS = 5;

    // Convert the word-length code into a bit count.
    function automatic logic [3:0] code_to_bits(input logic [1:0] code);
        return 4'(MIN_BITS) + {2'b00, code};
    endfunction
endpackage

// File: rtl/rx_sync.sv
// Input synchronizer: brings the asynchronous line into the clock domain.
// Assumes the line idles high, so every stage resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
// Frame engine: confirms the start bit, samples data, parity and stop bits
// at bit centres, and pulses `done` with the aligned word and its status.
// Assumes `tick` is a single-cycle enable at TICKS_PER_BIT times the bit rate.
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [3:0] DW4 = 4'(DATA_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [3:0]        bit_idx;
    logic [3:0]        nbits_q;
    logic              pen_q, podd_q, par_acc, perr_q;
    logic [DATA_W-1:0] shreg;

    // Walk the frame one tick at a time and publish each finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RXS_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            nbits_q <= 4'(MIN_BITS);
            pen_q   <= 1'b0;
            podd_q  <= 1'b0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
            shreg   <= '0;
            done    <= 1'b0;
            data    <= '0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RXS_IDLE: begin
                        if (!rx_s) begin
                            state   <= RXS_START;
                            cnt     <= '0;
                            bit_idx <= '0;
                            nbits_q <= code_to_bits(word_len);
                            pen_q   <= parity_en;
                            podd_q  <= parity_odd;
                            par_acc <= 1'b0;
                            perr_q  <= 1'b0;
                            shreg   <= '0;
                        end
                    end
                    RXS_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt   <= '0;
                            state <= rx_s ? RXS_IDLE : RXS_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RXS_DATA: begin
                        if (cnt == FULL_LAST) begin
                            cnt     <= '0;
                            shreg   <= {rx_s, shreg[DATA_W-1:1]};
                            par_acc <= par_acc ^ rx_s;
                            if (bit_idx == nbits_q - 1'b1)
                                state <= pen_q ? RXS_PAR : RXS_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RXS_PAR: begin
                        if (cnt == FULL_LAST) begin
                            cnt    <= '0;
                            perr_q <= par_acc ^ rx_s ^ podd_q;
                            state  <= RXS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RXS_STOP: begin
                        if (cnt == FULL_LAST) begin
                            cnt   <= '0;
                            done  <= 1'b1;
                            ferr  <= ~rx_s;
                            perr  <= pen_q & perr_q;
                            data  <= shreg >> (DW4 - nbits_q);
                            state <= RXS_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RXS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_holding.sv
// Holding register and host-visible flags for received words.
// Assumes `done` is a one-cycle pulse carrying a complete word and status.
module rx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              data_ready,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun
);
    logic accept;
    assign accept = done & (~data_ready | rd);

    // Store new words, flag lost words, and clear state on a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte     <= '0;
            data_ready  <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            overrun     <= 1'b0;
        end else if (accept) begin
            rx_byte     <= data_in;
            data_ready  <= 1'b1;
            parity_err  <= perr_in;
            framing_err <= ferr_in;
            overrun     <= 1'b0;
        end else if (done) begin
            overrun     <= 1'b1;
        end else if (rd) begin
            data_ready  <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            overrun     <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_top.sv
// Oversampling serial receiver: synchronizer, frame engine and holding register.
// Assumes tick16 comes from the transmitter's 16x bit-rate enable.
module serial_rx_top #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_line,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              data_ready,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun
);
    logic              rx_s;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              frame_perr, frame_ferr;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    rx_framer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
        .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
        .done(frame_done), .data(frame_data), .perr(frame_perr), .ferr(frame_ferr)
    );

    rx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .data_in(frame_data),
        .perr_in(frame_perr), .ferr_in(frame_ferr), .rd(rd_strobe),
        .rx_byte(rx_byte), .data_ready(data_ready), .parity_err(parity_err),
        .framing_err(framing_err), .overrun(overrun)
    );
endmodule

// File: rtl/serial_rx_checker.sv
// Property checker for the serial receiver, attached with bind.
// Assumes word_len is held steady while a frame is in progress.
module serial_rx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic [1:0]        word_len,
    input logic              frame_done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              data_ready,
    input logic              parity_err,
    input logic              framing_err,
    input logic              overrun
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!data_ready && !overrun && !parity_err && !framing_err && rx_byte == '0)); // R1

    AST_STORE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> data_ready); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> (!data_ready && !overrun && !parity_err && !framing_err)); // R7

    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && data_ready && !rd_strobe) |=> overrun); // R8

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && data_ready && !rd_strobe) |=>
            ($stable(rx_byte) && $stable(parity_err) && $stable(framing_err))); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !data_ready && word_len == 2'd0) |=> (rx_byte[DATA_W-1:5] == '0)); // R4

    AST_NO_PHANTOM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && !frame_done) |=> !data_ready); // R2
endmodule

bind serial_rx_top serial_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .word_len(word_len),
    .frame_done(frame_done), .rx_byte(rx_byte), .data_ready(data_ready),
    .parity_err(parity_err), .framing_err(framing_err), .overrun(overrun)
);

// File: tb/serial_rx_top_bench.sv
module serial_rx_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_byte;
    logic       data_ready, parity_err, framing_err, overrun;

    int n_checks = 0;
    int n_errors = 0;
    int div_cnt = 0;

    serial_rx_top u_serial_rx_top (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
        .rd_strobe(rd_strobe), .rx_byte(rx_byte), .data_ready(data_ready),
        .parity_err(parity_err), .framing_err(framing_err), .overrun(overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // 16x enable generated away from the active edge
    always @(negedge clk) begin
        div_cnt = (div_cnt + 1) % TICK_DIV;
        tick16 = (div_cnt == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one frame; bad_par flips the parity bit, stop_low holds the stop bit low
    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit podd, input bit bad_par, input bit stop_low);
        logic p;
        p = 1'b0;
        @(negedge clk);
        rx_line = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            p = p ^ d[i];
            wait_clks(BIT_CLKS);
        end
        if (pen) begin
            rx_line = p ^ podd ^ bad_par;
            wait_clks(BIT_CLKS);
        end
        if (stop_low) begin
            rx_line = 1'b0;
            wait_clks(48);
            rx_line = 1'b1;
            wait_clks(BIT_CLKS - 48);
        end else begin
            rx_line = 1'b1;
            wait_clks(BIT_CLKS);
        end
        wait_clks(16);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        wait_clks(1);
        rd_strobe = 1'b0;
        wait_clks(1);
    endtask

    task automatic set_fmt(input int nb, input bit pen, input bit podd);
        word_len   = 2'(nb - 5);
        parity_en  = pen;
        parity_odd = podd;
    endtask

    function automatic int mask_of(input int nb);
        return (1 << nb) - 1;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        wait_clks(190000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        wait_clks(4);
        // R1: reset state, checked while reset is held
        chk("R1 ready", data_ready, 0);
        chk("R1 byte", rx_byte, 0);
        chk("R1 flags", {parity_err, framing_err, overrun}, 0);
        rst_n = 1'b1;
        wait_clks(4);
        chk("R1 after release", {data_ready, parity_err, framing_err, overrun}, 0);

        // R3 R4 R5 R9: sweep every word length and parity mode
        for (int nb = 5; nb <= 8; nb++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 8; k++) begin
                    d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 73 + 5) & 255);
                    set_fmt(nb, pm != 0, pm == 2);
                    send_frame(d, nb, pm != 0, pm == 2, 1'b0, 1'b0);
                    chk("R3 R4 R9 byte", rx_byte, int'(d) & mask_of(nb));
                    chk("R7 ready set", data_ready, 1);
                    chk("R5 no parity error", parity_err, 0);
                    chk("R6 no framing error", framing_err, 0);
                    do_read();
                    chk("R7 ready cleared", data_ready, 0);
                end
            end
        end

        // R5: corrupted parity bit, even then odd
        for (int po = 0; po < 2; po++) begin
            set_fmt(7, 1'b1, po == 1);
            send_frame(8'h35, 7, 1'b1, po == 1, 1'b1, 1'b0);
            chk("R5 parity error", parity_err, 1);
            chk("R5 byte kept", rx_byte, 8'h35);
            do_read();
            chk("R7 read clears parity error", parity_err, 0);
        end

        // R6: stop bit low
        set_fmt(8, 1'b0, 1'b0);
        send_frame(8'hA6, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 framing error", framing_err, 1);
        chk("R6 byte", rx_byte, 8'hA6);
        wait_clks(4 * BIT_CLKS);
        chk("R2 no restart after stop", overrun, 0);
        do_read();
        chk("R7 read clears framing error", framing_err, 0);

        // R2: glitch shorter than half a bit
        set_fmt(8, 1'b0, 1'b0);
        @(negedge clk);
        rx_line = 1'b0;
        wait_clks(16);
        rx_line = 1'b1;
        wait_clks(12 * BIT_CLKS);
        chk("R2 glitch ignored", data_ready, 0);
        send_frame(8'h5C, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 frame after glitch", rx_byte, 8'h5C);
        do_read();

        // R8: second word without a read
        set_fmt(6, 1'b1, 1'b0);
        send_frame(8'h15, 6, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R8 first stored", rx_byte, 8'h15);
        chk("R8 no overrun yet", overrun, 0);
        send_frame(8'h2A, 6, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 overrun set", overrun, 1);
        chk("R8 old byte kept", rx_byte, 8'h15);
        chk("R8 old parity flag kept", parity_err, 1);
        do_read();
        chk("R7 R8 read clears overrun", {data_ready, overrun}, 0);

        finish_run();
    end
endmodule